// File: doc/BRIEF.md
# Power Domain Shutdown Sequencer

This controller turns a switchable clock/power domain off and back on when that domain is reached only through register-access crossings. A shutdown first closes the gate that lets the master side wait on the domain. With the gate closed, the crossings finish writes without effect and answer reads with the last captured value. The controller then waits until the crossings report no traffic in flight. Only then does it assert the domain reset, and it removes power while that reset is held. A power-up applies power under reset, waits for the supply to settle, releases reset, waits again, and reopens the gate as its last step.

Requests are single-cycle pulses. A request for the opposite direction that arrives while a sequence is running is remembered and started as soon as the running sequence completes. A request for the state the domain is already in is dropped. The power-settle and reset-hold intervals are cycle counts set by parameters, and one down-counter serves both. All outputs are registered in the controller's clock, so every change happens at a clock edge.

Top module: `domain_power_sequencer`

## Requirements
- R1: After reset the block reports OFF (status 2'b00), with domain reset high, power enable low, allow low and done low.
- R2: An off request sampled while ON lowers allow in the next cycle, with domain reset still low, power still high and status 2'b10 (transitioning).
- R3: Domain reset stays low while in-flight traffic is reported. It rises in the cycle after the first drain cycle that sees no traffic, and the drain phase lasts at least one cycle.
- R4: During shutdown, reset is held high with power still on for HOLD_CYC cycles, and power is only ever removed while reset is already high.
- R5: After power is removed, the block stays transitioning with power low for SETTLE_CYC cycles and then reports OFF (2'b00).
- R6: An on request sampled while OFF raises power with reset high and allow low for SETTLE_CYC cycles, then lowers reset with allow low for HOLD_CYC cycles, then raises allow and reports ON (2'b01).
- R7: done is high for exactly one cycle, the first cycle in which OFF or ON is reported at the end of a sequence.
- R8: status only takes the codes 2'b00 OFF, 2'b01 ON and 2'b10 transitioning.
- R9: An on request during a shutdown is held, and power-up starts in the cycle after OFF is first reported. An off request during a power-up is held likewise, and shutdown starts in the cycle after ON is first reported.
- R10: An on request while ON and an off request while OFF have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| off_req_i | input | 1 | One-cycle request to shut the domain down |
| on_req_i | input | 1 | One-cycle request to bring the domain up |
| inflight_i | input | 1 | High while any crossing still has a transaction outstanding |
| allow_o | output | 1 | Permission for the master side to wait on the domain |
| dom_rst_o | output | 1 | Active-high reset driven into the domain |
| pwr_en_o | output | 1 | Power switch enable for the domain |
| status_o | output | 2 | 00 OFF, 01 ON, 10 transitioning |
| done_o | output | 1 | One-cycle pulse when a sequence completes |

## Verification
The assertions check the ordering on every cycle. Reset may rise only with allow already low and after a cycle without traffic. Power may fall only under an established reset. Reset may fall only with power up and allow low. Allow may rise only out of reset. The assertions also confirm that status codes stay legal and that done stays a single pulse. The exact lengths of the drain, hold and settle phases, the hand-off of a pending request, and the dropping of redundant requests depend on counted windows and on stimulus history, so only the bench scenarios can show them.

// File: rtl/pwrseq_pkg.sv
// Shared types for the power domain sequencer: state encoding, status codes
// and the per-state output decode. Assumes nothing beyond IEEE 1800-2017.
package pwrseq_pkg;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_PWR_UP   = 3'd1,
        ST_RST_REL  = 3'd2,
        ST_ON       = 3'd3,
        ST_GATE     = 3'd4,
        ST_DRAIN    = 3'd5,
        ST_RST_HOLD = 3'd6,
        ST_PWR_DN   = 3'd7
    } seq_state_e;

    typedef enum logic [1:0] {
        STAT_OFF  = 2'b00,
        STAT_ON   = 2'b01,
        STAT_BUSY = 2'b10
    } seq_status_e;

    typedef struct packed {
        logic        allow;
        logic        dom_rst;
        logic        pwr_en;
        seq_status_e status;
    } seq_out_t;

    // Output levels that each state presents to the domain and the master side.
    function automatic seq_out_t decode_outputs(seq_state_e s);
        seq_out_t o;
        o = '{allow: 1'b0, dom_rst: 1'b1, pwr_en: 1'b0, status: STAT_OFF};
        case (s)
            ST_OFF:      o = '{allow: 1'b0, dom_rst: 1'b1, pwr_en: 1'b0, status: STAT_OFF};
            ST_PWR_UP:   o = '{allow: 1'b0, dom_rst: 1'b1, pwr_en: 1'b1, status: STAT_BUSY};
            ST_RST_REL:  o = '{allow: 1'b0, dom_rst: 1'b0, pwr_en: 1'b1, status: STAT_BUSY};
            ST_ON:       o = '{allow: 1'b1, dom_rst: 1'b0, pwr_en: 1'b1, status: STAT_ON};
            ST_GATE:     o = '{allow: 1'b0, dom_rst: 1'b0, pwr_en: 1'b1, status: STAT_BUSY};
            ST_DRAIN:    o = '{allow: 1'b0, dom_rst: 1'b0, pwr_en: 1'b1, status: STAT_BUSY};
            ST_RST_HOLD: o = '{allow: 1'b0, dom_rst: 1'b1, pwr_en: 1'b1, status: STAT_BUSY};
            ST_PWR_DN:   o = '{allow: 1'b0, dom_rst: 1'b1, pwr_en: 1'b0, status: STAT_BUSY};
            default:     o = '{allow: 1'b0, dom_rst: 1'b1, pwr_en: 1'b0, status: STAT_OFF};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/pwrseq_timer.sv
// Shared wait down-counter. A load sets the count; the count then decrements
// to zero and rests there. Assumes the caller loads on entry to each timed state.
module pwrseq_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // Wait windows in R4 rely on a strict single-step countdown.
    assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !expired_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_timer_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && expired_o) |=> expired_o);

endmodule

// File: rtl/pwrseq_pending.sv
// Holds one request for the opposite direction while a sequence runs.
// Assumes the sequencer clears a flag in the cycle it acts on it.
module pwrseq_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic on_req_i,
    input  logic off_req_i,
    input  logic dn_busy_i,
    input  logic up_busy_i,
    input  logic take_on_i,
    input  logic take_off_i,
    output logic pend_on_o,
    output logic pend_off_o
);

    logic pend_on_q;
    logic pend_off_q;

    // Remember an on request seen during shutdown until it is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_on_q <= 1'b0;
        end else if (take_on_i) begin
            pend_on_q <= 1'b0;
        end else if (on_req_i && dn_busy_i) begin
            pend_on_q <= 1'b1;
        end
    end

    // Remember an off request seen during power-up until it is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_off_q <= 1'b0;
        end else if (take_off_i) begin
            pend_off_q <= 1'b0;
        end else if (off_req_i && up_busy_i) begin
            pend_off_q <= 1'b1;
        end
    end

    assign pend_on_o  = pend_on_q;
    assign pend_off_o = pend_off_q;

    // R9: a held request points one way only.
    assert_pend_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_on_q && pend_off_q));

endmodule

// File: rtl/pwrseq_fsm.sv
// Sequencing state machine. Steps shutdown as gate, drain, reset hold, power
// down, and power-up as power on, reset release, open. Assumes the timer
// expires the cycle its count reaches zero.
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int SETTLE_CYC = 4,
    parameter int HOLD_CYC   = 4,
    parameter int CNT_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             on_req_i,
    input  logic             off_req_i,
    input  logic             inflight_i,
    input  logic             pend_on_i,
    input  logic             pend_off_i,
    input  logic             expired_i,
    output seq_state_e       state_d_o,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             take_on_o,
    output logic             take_off_o,
    output logic             dn_busy_o,
    output logic             up_busy_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       done_d;
    logic       done_q;

    // Next state, timer load and completion decision.
    always_comb begin
        state_d    = state_q;
        load_o     = 1'b0;
        load_val_o = HOLD_LD;
        done_d     = 1'b0;
        take_on_o  = 1'b0;
        take_off_o = 1'b0;
        case (state_q)
            ST_OFF: begin
                if (on_req_i || pend_on_i) begin
                    state_d    = ST_PWR_UP;
                    load_o     = 1'b1;
                    load_val_o = SETTLE_LD;
                    take_on_o  = 1'b1;
                end
            end
            ST_PWR_UP: begin
                if (expired_i) begin
                    state_d    = ST_RST_REL;
                    load_o     = 1'b1;
                    load_val_o = HOLD_LD;
                end
            end
            ST_RST_REL: begin
                if (expired_i) begin
                    state_d = ST_ON;
                    done_d  = 1'b1;
                end
            end
            ST_ON: begin
                if (off_req_i || pend_off_i) begin
                    state_d    = ST_GATE;
                    take_off_o = 1'b1;
                end
            end
            ST_GATE: begin
                state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!inflight_i) begin
                    state_d    = ST_RST_HOLD;
                    load_o     = 1'b1;
                    load_val_o = HOLD_LD;
                end
            end
            ST_RST_HOLD: begin
                if (expired_i) begin
                    state_d    = ST_PWR_DN;
                    load_o     = 1'b1;
                    load_val_o = SETTLE_LD;
                end
            end
            ST_PWR_DN: begin
                if (expired_i) begin
                    state_d = ST_OFF;
                    done_d  = 1'b1;
                end
            end
            default: begin
                state_d = ST_OFF;
            end
        endcase
    end

    // State and completion pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
        end
    end

    assign state_d_o = state_d;
    assign done_o    = done_q;
    assign dn_busy_o = (state_q == ST_GATE) || (state_q == ST_DRAIN) ||
                       (state_q == ST_RST_HOLD) || (state_q == ST_PWR_DN);
    assign up_busy_o = (state_q == ST_PWR_UP) || (state_q == ST_RST_REL);

    // R3: the drain phase is only left on a cycle without traffic.
    assert_drain_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && inflight_i) |=> (state_q == ST_DRAIN));

    // R2: gating always precedes draining.
    assert_gate_then_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GATE) |=> (state_q == ST_DRAIN));

endmodule

// File: rtl/pwrseq_outreg.sv
// Output register stage. Registers the decode of the next state so every
// output changes only at a clock edge. Assumes the OFF levels at reset.
module pwrseq_outreg
    import pwrseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e state_d_i,
    output logic       allow_o,
    output logic       dom_rst_o,
    output logic       pwr_en_o,
    output logic [1:0] status_o
);

    seq_out_t out_d;
    seq_out_t out_q;

    // Decode levels for the state being entered.
    always_comb begin
        out_d = decode_outputs(state_d_i);
    end

    // Capture the levels at the edge that enters the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '{allow: 1'b0, dom_rst: 1'b1, pwr_en: 1'b0, status: STAT_OFF};
        end else begin
            out_q <= out_d;
        end
    end

    assign allow_o   = out_q.allow;
    assign dom_rst_o = out_q.dom_rst;
    assign pwr_en_o  = out_q.pwr_en;
    assign status_o  = out_q.status;

endmodule

// File: rtl/domain_power_sequencer.sv
// Top of the power domain sequencer. Joins the state machine, the shared wait
// timer, the pending-request holder and the output registers. Assumes
// requests are one-cycle pulses and inflight_i is synchronous to clk.
module domain_power_sequencer
    import pwrseq_pkg::*;
#(
    parameter int SETTLE_CYC = 4,
    parameter int HOLD_CYC   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       off_req_i,
    input  logic       on_req_i,
    input  logic       inflight_i,
    output logic       allow_o,
    output logic       dom_rst_o,
    output logic       pwr_en_o,
    output logic [1:0] status_o,
    output logic       done_o
);

    localparam int MAX_WAIT = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
    localparam int CNT_W    = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1;

    seq_state_e       state_d;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    logic             pend_on;
    logic             pend_off;
    logic             take_on;
    logic             take_off;
    logic             dn_busy;
    logic             up_busy;

    pwrseq_fsm #(
        .SETTLE_CYC (SETTLE_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .on_req_i   (on_req_i),
        .off_req_i  (off_req_i),
        .inflight_i (inflight_i),
        .pend_on_i  (pend_on),
        .pend_off_i (pend_off),
        .expired_i  (expired),
        .state_d_o  (state_d),
        .load_o     (load),
        .load_val_o (load_val),
        .take_on_o  (take_on),
        .take_off_o (take_off),
        .dn_busy_o  (dn_busy),
        .up_busy_o  (up_busy),
        .done_o     (done_o)
    );

    pwrseq_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .expired_o  (expired)
    );

    pwrseq_pending u_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .on_req_i   (on_req_i),
        .off_req_i  (off_req_i),
        .dn_busy_i  (dn_busy),
        .up_busy_i  (up_busy),
        .take_on_i  (take_on),
        .take_off_i (take_off),
        .pend_on_o  (pend_on),
        .pend_off_o (pend_off)
    );

    pwrseq_outreg u_outreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_d_i (state_d),
        .allow_o   (allow_o),
        .dom_rst_o (dom_rst_o),
        .pwr_en_o  (pwr_en_o),
        .status_o  (status_o)
    );

    // R2: reset only rises once allow has been low for a cycle already.
    assert_allow_before_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_rst_o) |-> (!allow_o && !$past(allow_o)));

    // R3: reset only rises after a cycle with no traffic in flight.
    assert_reset_after_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_rst_o) |-> !$past(inflight_i));

    // R4: power only drops while reset was already held.
    assert_pwr_cut_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en_o) |-> (dom_rst_o && $past(dom_rst_o)));

    // R6: reset only releases with power already up and allow still low.
    assert_release_under_power_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_rst_o) |-> (pwr_en_o && $past(pwr_en_o) && !allow_o));

    // R6: allow rises last, out of an already released reset.
    assert_allow_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(allow_o) |-> (!dom_rst_o && !$past(dom_rst_o) && pwr_en_o));

    // R7: done is a single-cycle pulse.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: done coincides with a settled status.
    assert_done_settled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (status_o != 2'b10));

    // R8: only the three defined status codes appear.
    assert_status_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status_o != 2'b11);

endmodule

// File: tb/domain_power_sequencer_bench.sv
// Bench: directed corner cases plus seeded random sequences with a modelled
// traffic source; phase lengths are checked against the parameters.
module domain_power_sequencer_bench;

    localparam int SETTLE = 5;
    localparam int HOLD   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       off_req = 1'b0;
    logic       on_req = 1'b0;
    logic       inflight = 1'b0;
    logic       allow;
    logic       dom_rst;
    logic       pwr_en;
    logic [1:0] status;
    logic       done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    domain_power_sequencer #(
        .SETTLE_CYC (SETTLE),
        .HOLD_CYC   (HOLD)
    ) u_domain_power_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .off_req_i  (off_req),
        .on_req_i   (on_req),
        .inflight_i (inflight),
        .allow_o    (allow),
        .dom_rst_o  (dom_rst),
        .pwr_en_o   (pwr_en),
        .status_o   (status),
        .done_o     (done)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_drain(input int d);
        return (d > 1) ? d : 1;
    endfunction

    // Shutdown; when issue=0 the block is already in its first gated cycle.
    task automatic shutdown(input bit issue, input int d, input bit inj_on);
        int n;
        if (issue) begin
            off_req = 1'b1;
            @(negedge clk);
            off_req = 1'b0;
        end
        check("R2 allow low", allow, 0);
        check("R2 reset untouched", dom_rst, 0);
        check("R2 power untouched", pwr_en, 1);
        check("R8 status busy", status, 2);
        inflight = (d > 0);
        if (inj_on) on_req = 1'b1;
        n = 0;
        @(negedge clk);
        on_req = 1'b0;
        while (!dom_rst && n < 64) begin
            n++;
            if (n >= d) inflight = 1'b0;
            @(negedge clk);
        end
        check("R3 drain length", n, exp_drain(d));
        check("R3 allow during drain", allow, 0);
        n = 0;
        while (dom_rst && pwr_en && n < 64) begin
            n++;
            @(negedge clk);
        end
        check("R4 reset hold", n, HOLD);
        n = 0;
        while (!pwr_en && status == 2'b10 && n < 64) begin
            n++;
            @(negedge clk);
        end
        check("R5 settle off", n, SETTLE);
        check("R5 status off", status, 0);
        check("R5 reset held", dom_rst, 1);
        check("R7 done at off", done, 1);
        @(negedge clk);
        if (inj_on) begin
            check("R9 pending on starts", pwr_en, 1);
            check("R9 pending status", status, 2);
        end else begin
            check("R7 done one cycle", done, 0);
            check("R5 stays off", status, 0);
        end
    endtask

    // Power-up; when issue=0 the block is already in its first powered cycle.
    task automatic powerup(input bit issue, input bit inj_off);
        int n;
        if (issue) begin
            on_req = 1'b1;
            @(negedge clk);
            on_req = 1'b0;
        end
        check("R6 status busy", status, 2);
        if (inj_off) off_req = 1'b1;
        n = 0;
        while (pwr_en && dom_rst && !allow && n < 64) begin
            n++;
            @(negedge clk);
            off_req = 1'b0;
        end
        check("R6 settle under reset", n, SETTLE);
        n = 0;
        while (pwr_en && !dom_rst && !allow && n < 64) begin
            n++;
            @(negedge clk);
        end
        check("R6 released hold", n, HOLD);
        check("R6 allow last", allow, 1);
        check("R6 status on", status, 1);
        check("R7 done at on", done, 1);
        @(negedge clk);
        if (inj_off) begin
            check("R9 pending off starts", allow, 0);
            check("R9 pending status", status, 2);
        end else begin
            check("R7 done one cycle", done, 0);
            check("R6 stays on", status, 1);
        end
    endtask

    // A request for the current state must leave every output untouched.
    task automatic redundant(input bit on_state);
        if (on_state) on_req = 1'b1; else off_req = 1'b1;
        @(negedge clk);
        on_req = 1'b0;
        off_req = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R10 status kept", status, on_state ? 1 : 0);
            check("R10 allow kept", allow, on_state ? 1 : 0);
            check("R10 power kept", pwr_en, on_state ? 1 : 0);
            check("R10 no done", done, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit on_now;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 status", status, 0);
        check("R1 reset", dom_rst, 1);
        check("R1 power", pwr_en, 0);
        check("R1 allow", allow, 0);
        check("R1 done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle off", status, 0);

        powerup(1'b1, 1'b0);
        redundant(1'b1);
        shutdown(1'b1, 0, 1'b0);
        redundant(1'b0);
        powerup(1'b1, 1'b0);
        shutdown(1'b1, 4, 1'b0);
        powerup(1'b1, 1'b1);
        shutdown(1'b0, 2, 1'b0);
        powerup(1'b1, 1'b0);
        shutdown(1'b1, 1, 1'b1);
        powerup(1'b0, 1'b0);

        on_now = 1'b1;
        for (int i = 0; i < 30; i++) begin
            repeat ($urandom % 3) begin
                inflight = $urandom % 2;
                @(negedge clk);
            end
            if (on_now) begin
                bit inj;
                inj = $urandom % 2;
                shutdown(1'b1, $urandom % 7, inj);
                if (inj) powerup(1'b0, 1'b0);
                else on_now = 1'b0;
            end else begin
                bit inj;
                inj = $urandom % 2;
                powerup(1'b1, inj);
                if (inj) shutdown(1'b0, $urandom % 7, 1'b0);
                else on_now = 1'b1;
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule